// File: doc/BRIEF.md
# Code Block Slot Expander

The expander takes 256-bit code blocks, each made of eight 32-bit slots numbered 0 to 7, over a valid/ready handshake. It turns each block into a sequential stream of 32-bit or 16-bit instructions on a valid/ready output. Each output item carries the instruction, a size flag, a long-instruction tag, a duplicate flag and the slot it came from. Only one block is held at a time. A new block is taken only after the last instruction of the current one has been accepted.

A 3-bit field in the low bits of a two-address operate instruction has two meanings, and which one applies depends on the slot. In slot 0 it counts how many slots at the end of the block hold pseudo-immediates; those slots are never issued. In slots 1 to 7 it is a pointer. A copy of the slot it names is issued straight after the pointing instruction. Some pointers are illegal. These issue no copy and instead raise a one-cycle error pulse that carries the offending slot.

When a block reserves pseudo-immediate space, the whole block is copied into a retained register. Later blocks that reserve nothing use this copy, and a read port gives access to any of its slots. Slots that begin instructions longer than 32 bits are not assembled. They pass through as single 32-bit items with a tag.

Top module: `slot_expander`

## Requirements
- R1: After reset, ins_valid and dup_err are 0 and blk_ready is 1. A block is taken on a cycle with blk_valid and blk_ready both high. Its instructions then appear in ascending slot order starting at slot 0, and blk_ready stays low until the cycle after the last item is accepted.
- R2: If slot 0 has bit 16 = 0, bits [31:27] = 5'b01010 and bits [2:0] = N, with N nonzero, then slots 8-N to 7 are not issued. Slot 0 itself is still issued as a 32-bit instruction.
- R3: A slot with bit 16 = 1 and bits [31:27] not 5'b11111 is a pair. Its upper half [31:16] is issued first and its lower half [15:0] second. Both items have ins_half = 1 and are zero-extended to 32 bits.
- R4: A slot with bits [31:27] = 5'b11111 is issued once as a 32-bit word with ins_long = 1. Neither the pair rule nor the pointer rule applies to it.
- R5: In slot s (1 to 7), take an instruction with bit 16 = 0, bits [31:27] = 5'b01010 and a nonzero pointer p = bits [2:0]. If p is legal, the very next item has ins_dup = 1 and ins_slot = p. That item is the full word of slot p, or the word with ins_long = 1 if slot p is long.
- R6: When the duplicated slot is a pair, only its upper half is issued as the duplicate, as a 16-bit item.
- R7: A pointer to the first reserved slot (8-N) is legal. The duplicate is then the upper 16 bits of that slot, issued as a 16-bit item.
- R8: A pointer is illegal when it equals s, or when it names a reserved slot other than 8-N. In that case no duplicate is issued. dup_err is 1 for exactly the cycle after the pointing instruction is accepted, and dup_err_slot = s in that cycle.
- R9: On taking a block with N nonzero, the whole block is retained. pimm_word shows retained slot pimm_sel. Blocks with N = 0 leave the retained copy unchanged, and its reset value is all zeros.
- R10: While ins_valid is 1 and ins_ready is 0, the output item is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_valid | input | 1 | Code block offered |
| blk_ready | output | 1 | Expander can take a block |
| blk_data | input | 256 | Code block, slot k at bits [32k+31:32k] |
| ins_valid | output | 1 | Instruction item offered |
| ins_ready | input | 1 | Consumer takes the item |
| ins_word | output | 32 | Instruction; 16-bit items in the low half |
| ins_half | output | 1 | Item is a 16-bit instruction |
| ins_long | output | 1 | Item begins an instruction longer than 32 bits |
| ins_dup | output | 1 | Item is a pointer-inserted duplicate |
| ins_slot | output | 3 | Slot the item came from |
| dup_err | output | 1 | Illegal pointer pulse |
| dup_err_slot | output | 3 | Slot holding the illegal pointer |
| pimm_sel | input | 3 | Retained-block slot to read |
| pimm_word | output | 32 | Selected retained slot |

## Verification
The first item of a block appears on the outputs one clock edge after the block is accepted. Each later item appears one edge after the previous item is taken. The bench sets ins_ready at the falling edge and compares the item there whenever ready is high. dup_err comes from a register, so it is checked at the falling edge that follows the accepting rising edge. blk_ready is checked at that same falling edge after the block's last item. The retained-copy port is read a short delay after the falling edge that follows acceptance, once the new copy has been loaded.

// File: rtl/xp_pkg.sv
// Shared encodings for the code block slot expander.
// Assumes 32-bit slots, with the major opcode in the top five bits.
package xp_pkg;
    localparam int unsigned OP_W     = 5;
    localparam logic [4:0]  OP_OPR   = 5'b01010;
    localparam logic [4:0]  OP_LONG  = 5'b11111;
    localparam int unsigned PAIR_BIT = 16;

    // True when the major opcode marks the start of a long instruction.
    function automatic logic is_long(input logic [OP_W-1:0] op);
        return op == OP_LONG;
    endfunction

    // True when the slot is two 16-bit instructions.
    function automatic logic is_pair(input logic [OP_W-1:0] op, input logic pbit);
        return !is_long(op) && pbit;
    endfunction

    // True for a single 32-bit two-address operate instruction.
    function automatic logic is_opr(input logic [OP_W-1:0] op, input logic pbit);
        return !pbit && (op == OP_OPR);
    endfunction
endpackage

// File: rtl/xp_slot_decode.sv
// Decodes the item for the current slot and phase of a held block.
// Phase 0 is the slot's own instruction, or the upper half of a pair.
// Phase 1 is the lower half of a pair, or the duplicate named by the pointer.
// Assumes nres < NSLOT and that the cursor never points past the last instruction slot.
module xp_slot_decode
    import xp_pkg::*;
#(
    parameter int unsigned SLOT_W = 32,
    parameter int unsigned NSLOT  = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [SLOT_W*NSLOT-1:0] blk,
    input  logic [IDX_W-1:0]        nres,
    input  logic [IDX_W-1:0]        cur,
    input  logic                    second,
    output logic [SLOT_W-1:0]       word,
    output logic                    half,
    output logic                    long_ins,
    output logic                    dup,
    output logic [IDX_W-1:0]        src,
    output logic                    more,
    output logic                    err
);
    localparam int unsigned HALF_W = SLOT_W / 2;

    logic [SLOT_W-1:0] cw, pw;
    logic [IDX_W-1:0]  ptr, last, first_res;
    logic              c_long, c_pair, dup_req, legal, p_first, p_long, p_pair;

    // Classify the current slot and the slot its pointer names.
    always_comb begin
        cw        = blk[int'(cur)*SLOT_W +: SLOT_W];
        ptr       = cw[IDX_W-1:0];
        pw        = blk[int'(ptr)*SLOT_W +: SLOT_W];
        last      = IDX_W'(NSLOT - 1) - nres;
        first_res = last + 1'b1;
        c_long    = is_long(cw[SLOT_W-1 -: OP_W]);
        c_pair    = is_pair(cw[SLOT_W-1 -: OP_W], cw[PAIR_BIT]);
        dup_req   = is_opr(cw[SLOT_W-1 -: OP_W], cw[PAIR_BIT]) && (cur != '0) && (ptr != '0);
        p_first   = (nres != '0) && (ptr == first_res);
        legal     = (ptr != cur) && ((ptr <= last) || p_first);
        p_long    = is_long(pw[SLOT_W-1 -: OP_W]);
        p_pair    = is_pair(pw[SLOT_W-1 -: OP_W], pw[PAIR_BIT]);
    end

    // Build the output item for the current phase.
    always_comb begin
        word     = cw;
        half     = 1'b0;
        long_ins = 1'b0;
        dup      = 1'b0;
        src      = cur;
        more     = 1'b0;
        err      = 1'b0;
        if (!second) begin
            if (c_pair) begin
                word = {{HALF_W{1'b0}}, cw[SLOT_W-1 -: HALF_W]};
                half = 1'b1;
                more = 1'b1;
            end else begin
                long_ins = c_long;
                more     = dup_req && legal;
                err      = dup_req && !legal;
            end
        end else if (c_pair) begin
            word = {{HALF_W{1'b0}}, cw[HALF_W-1:0]};
            half = 1'b1;
        end else begin
            dup = 1'b1;
            src = ptr;
            if (p_first || p_pair) begin
                word = {{HALF_W{1'b0}}, pw[SLOT_W-1 -: HALF_W]};
                half = 1'b1;
            end else begin
                word     = pw;
                long_ins = p_long;
            end
        end
    end
endmodule

// File: rtl/xp_pimm_keep.sv
// Retains the most recent block that reserved pseudo-immediate space
// and serves one slot of it through a read port.
// Assumes ld is asserted only on the cycle a reserving block is taken.
module xp_pimm_keep #(
    parameter int unsigned SLOT_W = 32,
    parameter int unsigned NSLOT  = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld,
    input  logic [SLOT_W*NSLOT-1:0] din,
    input  logic [IDX_W-1:0]        sel,
    output logic [SLOT_W-1:0]       dout
);
    logic [SLOT_W*NSLOT-1:0] store_q;

    // Capture the reserving block; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  store_q <= '0;
        else if (ld) store_q <= din;
    end

    // Read port into the retained copy.
    always_comb dout = store_q[int'(sel)*SLOT_W +: SLOT_W];

    AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(store_q)); // R9
endmodule

// File: rtl/slot_expander.sv
// Code block slot expander: takes one block at a time and issues its
// instructions in slot order. Reserved slots are skipped, pairs are split,
// and pointer duplicates are inserted. The last reserving block is retained.
// Assumes a consumer with valid/ready; one block is held at a time.
module slot_expander
    import xp_pkg::*;
#(
    parameter int unsigned SLOT_W = 32,
    parameter int unsigned NSLOT  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    blk_valid,
    output logic                    blk_ready,
    input  logic [SLOT_W*NSLOT-1:0] blk_data,
    output logic                    ins_valid,
    input  logic                    ins_ready,
    output logic [SLOT_W-1:0]       ins_word,
    output logic                    ins_half,
    output logic                    ins_long,
    output logic                    ins_dup,
    output logic [$clog2(NSLOT)-1:0] ins_slot,
    output logic                    dup_err,
    output logic [$clog2(NSLOT)-1:0] dup_err_slot,
    input  logic [$clog2(NSLOT)-1:0] pimm_sel,
    output logic [SLOT_W-1:0]       pimm_word
);
    localparam int unsigned IDX_W = $clog2(NSLOT);
    localparam int unsigned BLK_W = SLOT_W * NSLOT;

    logic [BLK_W-1:0] blk_q;
    logic [IDX_W-1:0] nres_q, cur_q, last, in_nres, err_slot_q;
    logic             busy_q, ph_q, err_q, accept, fire, d_more, d_err;

    // Handshake and the reservation count of an incoming block.
    always_comb begin
        blk_ready = !busy_q;
        ins_valid = busy_q;
        accept    = blk_valid && blk_ready;
        fire      = ins_valid && ins_ready;
        last      = IDX_W'(NSLOT - 1) - nres_q;
        in_nres   = is_opr(blk_data[SLOT_W-1 -: OP_W], blk_data[PAIR_BIT])
                    ? blk_data[IDX_W-1:0] : '0;
    end

    // Slot cursor and phase: load on accept, advance on each taken item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            nres_q <= '0;
            cur_q  <= '0;
            ph_q   <= 1'b0;
            busy_q <= 1'b0;
        end else if (accept) begin
            blk_q  <= blk_data;
            nres_q <= in_nres;
            cur_q  <= '0;
            ph_q   <= 1'b0;
            busy_q <= 1'b1;
        end else if (fire) begin
            if (d_more) begin
                ph_q <= 1'b1;
            end else if (cur_q == last) begin
                busy_q <= 1'b0;
            end else begin
                cur_q <= cur_q + 1'b1;
                ph_q  <= 1'b0;
            end
        end
    end

    // One-cycle error pulse after an instruction with an illegal pointer is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= 1'b0;
            err_slot_q <= '0;
        end else begin
            err_q <= fire && d_err;
            if (fire && d_err) err_slot_q <= cur_q;
        end
    end

    assign dup_err      = err_q;
    assign dup_err_slot = err_slot_q;

    xp_slot_decode #(.SLOT_W(SLOT_W), .NSLOT(NSLOT), .IDX_W(IDX_W)) u_dec (
        .blk      (blk_q),
        .nres     (nres_q),
        .cur      (cur_q),
        .second   (ph_q),
        .word     (ins_word),
        .half     (ins_half),
        .long_ins (ins_long),
        .dup      (ins_dup),
        .src      (ins_slot),
        .more     (d_more),
        .err      (d_err)
    );

    xp_pimm_keep #(.SLOT_W(SLOT_W), .NSLOT(NSLOT), .IDX_W(IDX_W)) u_keep (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (accept && (in_nres != '0)),
        .din   (blk_data),
        .sel   (pimm_sel),
        .dout  (pimm_word)
    );

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready |=> ins_valid && $stable(ins_word) && $stable(ins_slot) && $stable(ins_dup)); // R10
    AST_NO_RES_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_dup |-> ins_slot <= last); // R2
    AST_DUP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_dup |-> (ins_slot <= last) || (ins_slot == last + 1'b1)); // R8
    AST_HALF_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_half |-> ins_word[SLOT_W-1 -: SLOT_W/2] == '0); // R3
    AST_ERR_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err |-> !(ins_valid && ins_dup)); // R8
endmodule

// File: tb/sim_slot_expander.sv
module sim_slot_expander;
    logic         clk = 1'b0, rst_n = 1'b0;
    logic         blk_valid = 1'b0, ins_ready = 1'b0;
    logic [255:0] blk_data = '0;
    logic [2:0]   pimm_sel = '0;
    logic         blk_ready, ins_valid, ins_half, ins_long, ins_dup, dup_err;
    logic [31:0]  ins_word, pimm_word;
    logic [2:0]   ins_slot, dup_err_slot;

    int tests = 0, fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    slot_expander u0 (.*);

    // Expected item list for the block being run.
    logic [31:0]  e_word [0:23];
    logic         e_half [0:23], e_long [0:23], e_dup [0:23], e_err [0:23];
    logic [2:0]   e_slot [0:23];
    int           n_exp;
    logic [255:0] ret = '0;

    task automatic chk(input bit ok, input string req, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic bit w_long(input logic [31:0] w); return w[31:27] == 5'b11111; endfunction
    function automatic bit w_pair(input logic [31:0] w); return !w_long(w) && w[16]; endfunction
    function automatic bit w_opr (input logic [31:0] w); return !w[16] && w[31:27] == 5'b01010; endfunction
    function automatic logic [2:0] res_n(input logic [255:0] b);
        return w_opr(b[31:0]) ? b[2:0] : 3'd0;
    endfunction

    task automatic push(input logic [31:0] w, input logic h, input logic l,
                        input logic d, input logic [2:0] s, input logic e);
        e_word[n_exp] = w; e_half[n_exp] = h; e_long[n_exp] = l;
        e_dup[n_exp] = d;  e_slot[n_exp] = s; e_err[n_exp] = e;
        n_exp++;
    endtask

    // Reference model built from the requirements.
    task automatic build_exp(input logic [255:0] b);
        int nr = int'(res_n(b));
        int last = 7 - nr;
        n_exp = 0;
        for (int s = 0; s <= last; s++) begin
            logic [31:0] w = b[s*32 +: 32];
            if (w_long(w)) push(w, 0, 1, 0, 3'(s), 0);
            else if (w_pair(w)) begin
                push({16'b0, w[31:16]}, 1, 0, 0, 3'(s), 0);
                push({16'b0, w[15:0]},  1, 0, 0, 3'(s), 0);
            end else if (s != 0 && w_opr(w) && w[2:0] != 0) begin
                int p = int'(w[2:0]);
                bit first = (nr != 0) && (p == 8 - nr);
                bit legal = (p != s) && (p <= last || first);
                logic [31:0] t = b[p*32 +: 32];
                push(w, 0, 0, 0, 3'(s), !legal);
                if (legal) begin
                    if (first || w_pair(t)) push({16'b0, t[31:16]}, 1, 0, 1, 3'(p), 0);
                    else push(t, 0, w_long(t), 1, 3'(p), 0);
                end
            end else push(w, 0, 0, 0, 3'(s), 0);
        end
    endtask

    function automatic string tag(input int i);
        if (e_dup[i] && e_half[i]) return "R6";
        if (e_dup[i]) return "R5";
        if (e_long[i]) return "R4";
        if (e_half[i]) return "R3";
        return "R1";
    endfunction

    function automatic logic [31:0] mk_op(input logic [2:0] f);
        logic [31:0] r = $urandom;
        r[31:27] = 5'b01010; r[16] = 1'b0; r[2:0] = f;
        return r;
    endfunction
    function automatic logic [31:0] mk_pair();
        logic [31:0] r = $urandom;
        r[16] = 1'b1; if (r[31:27] == 5'b11111) r[31] = 1'b0;
        return r;
    endfunction
    function automatic logic [31:0] mk_long();
        logic [31:0] r = $urandom;
        r[31:27] = 5'b11111;
        return r;
    endfunction
    function automatic logic [31:0] mk_plain();
        logic [31:0] r = $urandom;
        r[16] = 1'b0;
        if (r[31:27] == 5'b01010 || r[31:27] == 5'b11111) r[31:27] = 5'b00001;
        return r;
    endfunction
    function automatic logic [31:0] mk_any();
        case ($urandom % 4)
            0: return mk_op(3'($urandom));
            1: return mk_pair();
            2: return mk_long();
            default: return mk_plain();
        endcase
    endfunction

    // Offer one block, then take and check every item it produces.
    task automatic run_block(input logic [255:0] b);
        bit          err_prev = 0, hold = 0;
        logic [2:0]  err_slot_prev = 0;
        logic [31:0] hold_word = 0;
        int          idx = 0, guard = 0;
        build_exp(b);
        @(negedge clk);
        chk(blk_ready === 1'b1, "R1", $sformatf("blk_ready %b exp 1", blk_ready));
        blk_valid = 1'b1; blk_data = b;
        @(posedge clk);
        @(negedge clk);
        blk_valid = 1'b0;
        if (res_n(b) != 0) ret = b;
        pimm_sel = 3'($urandom);
        #1;
        chk(pimm_word === ret[pimm_sel*32 +: 32], "R9",
            $sformatf("pimm_word %h exp %h", pimm_word, ret[pimm_sel*32 +: 32]));
        while (idx < n_exp && guard < 200) begin
            guard++;
            if (hold) chk(ins_valid === 1'b1 && ins_word === hold_word, "R10",
                          $sformatf("held word %h exp %h", ins_word, hold_word));
            chk(dup_err === err_prev && (!err_prev || dup_err_slot === err_slot_prev), "R8",
                $sformatf("dup_err %b slot %0d exp %b slot %0d", dup_err, dup_err_slot, err_prev, err_slot_prev));
            ins_ready = ($urandom % 4) != 0;
            #1;
            err_prev = 0; hold = 0;
            if (ins_ready) begin
                chk(ins_valid === 1'b1 && ins_word === e_word[idx] && ins_half === e_half[idx] &&
                    ins_long === e_long[idx] && ins_dup === e_dup[idx] && ins_slot === e_slot[idx],
                    tag(idx), $sformatf("item %0d v%b w%h h%b l%b d%b s%0d exp w%h h%b l%b d%b s%0d",
                    idx, ins_valid, ins_word, ins_half, ins_long, ins_dup, ins_slot,
                    e_word[idx], e_half[idx], e_long[idx], e_dup[idx], e_slot[idx]));
                err_prev = e_err[idx]; err_slot_prev = e_slot[idx];
                idx++;
            end else begin
                hold = 1; hold_word = ins_word;
            end
            @(posedge clk);
            @(negedge clk);
        end
        ins_ready = 1'b0;
        chk(dup_err === err_prev && (!err_prev || dup_err_slot === err_slot_prev), "R8",
            $sformatf("dup_err %b slot %0d exp %b slot %0d", dup_err, dup_err_slot, err_prev, err_slot_prev));
        chk(ins_valid === 1'b0 && blk_ready === 1'b1, "R1",
            $sformatf("end valid %b ready %b exp 0 1", ins_valid, blk_ready));
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++; tests++;
                $display("FAIL watchdog: cycles %0d exp below 150000", cyc);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [255:0] b;
        void'($urandom(32'd20240423));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(ins_valid === 1'b0 && blk_ready === 1'b1 && dup_err === 1'b0, "R1",
            $sformatf("reset valid %b ready %b err %b exp 0 1 0", ins_valid, blk_ready, dup_err));
        chk(pimm_word === 32'd0, "R9", $sformatf("reset pimm %h exp 0", pimm_word));

        // R2 R7 R5: three reserved (5..7); pointer to first reserved and to a plain slot.
        b = '0;
        b[0*32 +: 32] = mk_op(3'd3);
        b[1*32 +: 32] = mk_op(3'd5);
        b[2*32 +: 32] = mk_op(3'd3);
        b[3*32 +: 32] = mk_plain();
        b[4*32 +: 32] = mk_pair();
        b[5*32 +: 32] = 32'hABCD_1234;
        b[6*32 +: 32] = mk_plain();
        b[7*32 +: 32] = mk_long();
        run_block(b);

        // R8 R6 R4: two reserved (6,7); pointer past first reserved, pointer to self, pointer to a pair.
        b = '0;
        b[0*32 +: 32] = mk_op(3'd2);
        b[1*32 +: 32] = mk_op(3'd7);
        b[2*32 +: 32] = mk_op(3'd2);
        b[3*32 +: 32] = mk_op(3'd4);
        b[4*32 +: 32] = mk_pair();
        b[5*32 +: 32] = mk_long();
        b[6*32 +: 32] = mk_plain();
        b[7*32 +: 32] = mk_plain();
        run_block(b);

        // R9: no reservation leaves the retained copy as is; R5 pointer back to slot 1.
        b = '0;
        b[0*32 +: 32] = mk_plain();
        for (int k = 1; k < 7; k++) b[k*32 +: 32] = mk_plain();
        b[7*32 +: 32] = mk_op(3'd1);
        run_block(b);

        // Random blocks.
        for (int n = 0; n < 150; n++) begin
            for (int k = 0; k < 8; k++) b[k*32 +: 32] = mk_any();
            if ($urandom % 3 == 0) b[31:0] = mk_op(3'(1 + $urandom % 7));
            run_block(b);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule